// File: doc/BRIEF.md
# Windowed Register File

This block gives a processor core thirty-two architectural registers on top of a larger circular physical array. Eight of the architectural registers are shared by every procedure. The other twenty-four come from a window that slides through the physical array. A call strobes `save_req` to move to a fresh window. A return strobes `restore_req` to move back.

Neighbouring windows overlap by eight registers. Argument values that a caller places in its outgoing registers therefore show up in the callee's incoming registers without any copy. Each window has eight registers of its own that no other window can see.

The block has two combinational read ports and one write port that commits at the clock edge, all addressed by 5-bit architectural numbers. It counts how many windows are in use. When a save would reuse the one free window that keeps the ring from wrapping onto itself, the block raises `ovf_o` and does not move. When a restore is attempted from the last window, it raises `unf_o` and does not move. Spilling windows to memory is left to the trap logic outside this block.

Top module: `regwin_file`

## Requirements
- R1: Architectural registers 1 to 7 are shared. They address the same storage in every window, and a save or restore never changes what they read.
- R2: Register 0 reads as zero on both read ports, and a write to it is dropped.
- R3: In each window, registers 8-15 are outgoing, 16-23 are private and 24-31 are incoming. After an accepted save, register 24+k reads what register 8+k of the previous window held, for k = 0..7. This includes stack pointer 14 → frame pointer 30 and return link 15 → 31.
- R4: The private registers 16-23 of a window cannot be reached through 16-23 of any other window that is in use. A value written there before a save reads back again after the matching restore.
- R5: An accepted restore returns exactly to the window that was current before the matching save, so every register of the caller reads its earlier contents.
- R6: With NWIN-1 windows in use, `save_req` raises `ovf_o` in the same cycle and the window does not change. Otherwise a save is accepted and `ovf_o` stays low.
- R7: With one window in use, `restore_req` (without `save_req`) raises `unf_o` in the same cycle and the window does not change. Otherwise `unf_o` stays low.
- R8: A read of the register being written in the same cycle returns the old value. The new value is readable from the next cycle on.
- R9: A write in the same cycle as a save or restore lands in the window that was current before that edge.
- R10: After reset one window is in use, so the first restore underflows. Exactly NWIN-2 saves are then accepted before a save overflows.
- R11: When `save_req` and `restore_req` are high together, the save is acted on and the restore is ignored. `unf_o` stays low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | DW | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | DW | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to a fresh window at this edge |
| restore_req | input | 1 | Return to the previous window at this edge |
| ovf_o | output | 1 | Save refused: the window ring is full |
| unf_o | output | 1 | Restore refused: only one window is in use |

## Verification
The bench aims at the seam between windows. It checks that outgoing values written by a caller appear as incoming values in the callee. A wrong offset in the translation would return another window's data there, or stale data. It hides and then re-exposes private registers across a save and restore pair. A translation that ignored the window number would let the callee overwrite the caller's data.

It fills the ring to the overflow point and drains it to underflow, then confirms through register reads that the refused step left the window where it was. A counter that is off by one would show a flag one call early or late.

It also aims the write at the edge of a save and aims a read at the register being written. A design that translated the write with the new pointer, or forwarded write data to the read port, would return the wrong value there. A long random run against a behavioural model checks every read on every cycle.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int ARCH_W     = 5;
  localparam int N_GLOBALS  = 8;
  localparam int WIN_STRIDE = 16;
  typedef logic [ARCH_W-1:0] arch_idx_t;
endpackage

// File: rtl/regwin_rstsync.sv
module regwin_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN = 8,
  localparam int PW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CW = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  output logic [PW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [PW-1:0] cwp_q, cwp_d;
  logic [CW-1:0] used_q, used_d;
  logic full, last, do_save, do_rest, step_en;

  assign full    = (used_q == CW'(NWIN - 1));
  assign last    = (used_q == CW'(1));
  assign do_save = save_req & ~full;
  assign do_rest = restore_req & ~save_req & ~last;
  assign step_en = do_save | do_rest;
  assign ovf_o   = save_req & full;
  assign unf_o   = restore_req & ~save_req & last;
  assign cwp_o   = cwp_q;

  always_comb begin
    cwp_d  = cwp_q;
    used_d = used_q;
    if (do_save) begin
      cwp_d  = (cwp_q == '0) ? PW'(NWIN - 1) : cwp_q - PW'(1);
      used_d = used_q + CW'(1);
    end else if (do_rest) begin
      cwp_d  = (cwp_q == PW'(NWIN - 1)) ? '0 : cwp_q + PW'(1);
      used_d = used_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      used_q <= CW'(1);
    end else if (step_en) begin
      cwp_q  <= cwp_d;
      used_q <= used_d;
    end
  end

  // R6
  save_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && ovf_o) |=> $stable(cwp_q));
  // R7
  restore_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && unf_o) |=> $stable(cwp_q));
  // R6
  save_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !ovf_o) |=> (used_q == $past(used_q) + CW'(1)));
  // R10
  occupancy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q >= CW'(1)) && (used_q <= CW'(NWIN - 1)));
  // R11
  save_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |-> !unf_o);
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int PIW  = 8,
  localparam int PW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int SW = PIW + 1,
  localparam int WREGS = WIN_STRIDE * NWIN
) (
  input  logic [PW-1:0]  cwp,
  input  arch_idx_t      idx,
  output logic [PIW-1:0] phys
);
  logic [SW-1:0] raw, wrapped;

  always_comb begin
    raw     = (SW'(cwp) * SW'(WIN_STRIDE)) + SW'(idx) - SW'(N_GLOBALS);
    wrapped = (raw >= SW'(WREGS)) ? raw - SW'(WREGS) : raw;
    if (idx < arch_idx_t'(N_GLOBALS)) phys = PIW'(idx);
    else                              phys = PIW'(wrapped + SW'(N_GLOBALS));
  end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PIW   = 8
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [PIW-1:0] wr_phys,
  input  logic [DW-1:0]  wr_data,
  input  logic [PIW-1:0] ra_phys,
  input  logic [PIW-1:0] rb_phys,
  output logic [DW-1:0]  ra_data,
  output logic [DW-1:0]  rb_data
);
  logic [DW-1:0] mem [NPHYS];
  logic wr_go;

  assign wr_go = wr_en & (wr_phys != '0);

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_phys] <= wr_data;
  end

  assign ra_data = (ra_phys == '0) ? '0 : mem[ra_phys];
  assign rb_data = (rb_phys == '0) ? '0 : mem[rb_phys];
endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int NPHYS = N_GLOBALS + WIN_STRIDE * NWIN,
  localparam int PIW   = $clog2(NPHYS),
  localparam int PW    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          save_req,
  input  logic          restore_req,
  output logic          ovf_o,
  output logic          unf_o
);
  logic           rst_n_sync;
  logic [PW-1:0]  cwp;
  logic [PIW-1:0] ra_phys, rb_phys, wr_phys;

  regwin_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  regwin_ptr #(.NWIN(NWIN)) u_ptr (
    .clk(clk), .rst_n(rst_n_sync), .save_req(save_req),
    .restore_req(restore_req), .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  regwin_xlate #(.NWIN(NWIN), .PIW(PIW)) u_xa (.cwp(cwp), .idx(rd_a_idx), .phys(ra_phys));
  regwin_xlate #(.NWIN(NWIN), .PIW(PIW)) u_xb (.cwp(cwp), .idx(rd_b_idx), .phys(rb_phys));
  regwin_xlate #(.NWIN(NWIN), .PIW(PIW)) u_xw (.cwp(cwp), .idx(wr_idx),   .phys(wr_phys));

  regwin_store #(.DW(DW), .NPHYS(NPHYS), .PIW(PIW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_phys(wr_phys), .wr_data(wr_data),
    .ra_phys(ra_phys), .rb_phys(rb_phys), .ra_data(rd_a_data), .rb_data(rd_b_data)
  );

  // R2
  zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
  // R2
  zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
  // R1
  global_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_a_idx < 5'd8) |-> (ra_phys == PIW'(rd_a_idx)));
  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(ovf_o && unf_o));
endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN  = 8;
  localparam int DW    = 32;
  localparam int NPHYS = 8 + 16 * NWIN;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic wr_en, save_req, restore_req, ovf_o, unf_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] mem_m [NPHYS];
  bit            known_m [NPHYS];
  int            cwp_m, used_m;
  logic [DW-1:0] s_a, s_b;
  logic          s_ovf, s_unf;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_file #(.NWIN(NWIN), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .save_req(save_req), .restore_req(restore_req),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic int pidx(int w, int r);
    if (r < 8) return r;
    return ((w * 16 + r - 8) % (16 * NWIN)) + 8;
  endfunction

  function automatic string tag_of(int r);
    if (r == 0) return "R2";
    if (r < 8)  return "R1";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input int wi, input logic [DW-1:0] wd,
                     input bit sv, input bit rs, input int ra, input int rb);
    logic exp_ovf, exp_unf;
    int pa, pb;
    @(negedge clk);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    save_req = sv; restore_req = rs;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    s_a = rd_a_data; s_b = rd_b_data; s_ovf = ovf_o; s_unf = unf_o;
    exp_ovf = sv && (used_m == NWIN - 1);
    exp_unf = rs && !sv && (used_m == 1);
    chk("R6 ovf_o", {31'd0, s_ovf}, {31'd0, exp_ovf});
    chk("R7 unf_o", {31'd0, s_unf}, {31'd0, exp_unf});
    pa = pidx(cwp_m, ra); pb = pidx(cwp_m, rb);
    if (ra == 0) chk("R2 port A", s_a, '0);
    else if (known_m[pa]) chk(tag_of(ra), s_a, mem_m[pa]);
    if (rb == 0) chk("R2 port B", s_b, '0);
    else if (known_m[pb]) chk(tag_of(rb), s_b, mem_m[pb]);
    @(posedge clk);
    if (we && wi != 0) begin
      mem_m[pidx(cwp_m, wi)] = wd;
      known_m[pidx(cwp_m, wi)] = 1'b1;
    end
    if (sv) begin
      if (!exp_ovf) begin cwp_m = (cwp_m + NWIN - 1) % NWIN; used_m++; end
    end else if (rs && !exp_unf) begin
      cwp_m = (cwp_m + 1) % NWIN; used_m--;
    end
  endtask

  task automatic wr(input int r, input logic [DW-1:0] d);
    cyc(1'b1, r, d, 1'b0, 1'b0, r, 0);
  endtask
  task automatic rd(input int r);
    cyc(1'b0, 0, '0, 1'b0, 1'b0, r, 0);
  endtask
  task automatic do_save();
    cyc(1'b0, 0, '0, 1'b1, 1'b0, 0, 0);
  endtask
  task automatic do_restore();
    cyc(1'b0, 0, '0, 1'b0, 1'b1, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_data = 0;
    save_req = 0; restore_req = 0; rd_a_idx = 0; rd_b_idx = 0;
    cwp_m = 0; used_m = 1;
    for (int i = 0; i < NPHYS; i++) known_m[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset leaves one window in use, so a restore underflows
    do_restore();
    chk("R10 first restore underflows", {31'd0, s_unf}, 32'd1);

    // R2: write to register 0 dropped
    wr(0, 32'hDEAD_BEEF);
    rd(0);
    chk("R2 r0 reads zero", s_a, 32'd0);

    // R1: globals survive save and restore
    wr(5, 32'h1111_0005);
    do_save();
    rd(5);
    chk("R1 global after save", s_a, 32'h1111_0005);
    do_restore();
    rd(5);
    chk("R1 global after restore", s_a, 32'h1111_0005);

    // R3: outgoing becomes incoming
    wr(8,  32'hAAAA_0008);
    wr(14, 32'hAAAA_000E);
    wr(15, 32'hAAAA_000F);
    do_save();
    rd(24); chk("R3 r8->r24", s_a, 32'hAAAA_0008);
    rd(30); chk("R3 sp->fp", s_a, 32'hAAAA_000E);
    rd(31); chk("R3 r15->r31", s_a, 32'hAAAA_000F);

    // R4/R5: private registers and exact return
    do_restore();
    wr(16, 32'hBBBB_0016);
    do_save();
    wr(16, 32'hCCCC_0016);
    rd(16); chk("R4 callee private", s_a, 32'hCCCC_0016);
    do_restore();
    rd(16); chk("R4 caller private back", s_a, 32'hBBBB_0016);
    rd(8);  chk("R5 caller outgoing back", s_a, 32'hAAAA_0008);

    // R8: read during write returns old value
    wr(9, 32'h0000_0001);
    cyc(1'b1, 9, 32'h0000_0002, 1'b0, 1'b0, 9, 0);
    chk("R8 old value same cycle", s_a, 32'h0000_0001);
    rd(9); chk("R8 new value next cycle", s_a, 32'h0000_0002);

    // R9: write with save lands in old window
    cyc(1'b1, 8, 32'h5555_0008, 1'b1, 1'b0, 0, 0);
    rd(24); chk("R9 write used old window", s_a, 32'h5555_0008);
    do_restore();

    // R6/R10: NWIN-2 saves accepted, next refused
    for (int i = 0; i < NWIN - 2; i++) begin
      do_save();
      chk("R10 save accepted", {31'd0, s_ovf}, 32'd0);
    end
    wr(16, 32'h7777_0016);
    do_save();
    chk("R6 overflow flagged", {31'd0, s_ovf}, 32'd1);
    rd(16); chk("R6 window unchanged", s_a, 32'h7777_0016);

    // R7: drain to underflow
    for (int i = 0; i < NWIN - 2; i++) do_restore();
    do_restore();
    chk("R7 underflow flagged", {31'd0, s_unf}, 32'd1);
    rd(16); chk("R7 window unchanged", s_a, 32'hBBBB_0016);

    // R11: save and restore together act as save
    wr(8, 32'h9999_0008);
    cyc(1'b0, 0, '0, 1'b1, 1'b1, 0, 0);
    chk("R11 no underflow flag", {31'd0, s_unf}, 32'd0);
    rd(24); chk("R11 save acted on", s_a, 32'h9999_0008);
    do_restore();

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom % 8);
      cyc(($urandom % 2) == 0, int'($urandom % 32), $urandom,
          k == 0, k == 1, int'($urandom % 32), int'($urandom % 32));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule